// File: doc/BRIEF.md
# Parallel Flash Programming Sequencer

This block is the host-side master that programs an 8051-class microcontroller through its parallel flash programming pins. On a start pulse it powers the target up in a fixed order, waits for the target oscillator to settle, then pulls code bytes from a valid/ready stream. Each byte goes through the same steps. The sequencer sets up the mode lines, address and data. It raises the programming-voltage request and gives one program strobe. It waits for the self-timed write to finish, then reads the byte back and compares it with what was written.

Write completion is found in one of two ways, chosen per session by a configuration input: by watching the target's ready/busy line, or by polling bit 7 of the data port. During a write the target returns the inverse of the written bit 7. The session ends after the byte carrying the last flag, or when the address reaches the last programmable location. A completion timeout or a read-back mismatch also ends the session. In every case the target is powered down in reverse order, and `done` is raised. A failure also leaves `err`, the cause and the failing address visible until the next start.

All delays (settling, setup, strobe width, completion timeout) are parameters counted in system clock cycles. The 12 V supply itself is outside the block: `tgt_vpp_en` only requests it.

Top module: `flashprog_seq`

## Requirements
- R1: Power-up steps through the supply enable, then the target reset one cycle later, then the target clock enable one cycle after that.
- R2: For at least PWRUP_CYC cycles after the target clock starts, nothing else changes. Then EA and ALE go high, PSEN stays low and all four mode lines are high (4'b1111). Only after that does `s_ready` ever assert.
- R3: For each byte, the mode lines carry the write code 4'b0111 (bit 3 = P2.6, bit 2 = P2.7, bit 1 = P3.6, bit 0 = P3.7). `tgt_doe` is high and the address and data are held stable before `tgt_vpp_en` rises, SETUP_CYC cycles later.
- R4: Exactly one low pulse on `tgt_ale_prog` is issued per byte, STROBE_CYC cycles wide, with `tgt_vpp_en` high throughout.
- R5: With `poll_sel`=0, the write is complete once `tgt_rdy` has been seen low and then reads high.
- R6: With `poll_sel`=1, the mode lines carry the read code 4'b0011 while waiting. The write is complete when `tgt_din[7]` equals bit 7 of the written byte.
- R7: Read-back uses the read code 4'b0011 with `tgt_doe` low, and samples `tgt_din` after SETUP_CYC cycles. A matching byte lets the session continue without error.
- R8: Addresses start at 0 and rise by one per byte. `tgt_addr[7:0]` drives port 1 and `tgt_addr[13:8]` drives P2.0–P2.5. The session stops after the byte flagged `s_last` or after address MAX_BYTES-1, whichever comes first.
- R9: If completion is not seen within TIMEOUT_CYC cycles, the session powers off with `err`=1, `err_timeout`=1 and `err_addr` holding the failing address.
- R10: A read-back mismatch powers off with `err`=1, `err_timeout`=0 and `err_addr` holding the failing address.
- R11: Power-off turns the target clock off first. Reset and EA fall one cycle later, and the supply falls one cycle after that. `done` is then high and all target outputs are low.
- R12: After reset, all target outputs, `s_ready`, `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a session when idle |
| poll_sel | input | 1 | 0: ready/busy completion, 1: bit-7 data polling |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | DATA_W | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Sequencer takes a byte |
| tgt_din | input | DATA_W | Target data port as read |
| tgt_rdy | input | 1 | Target ready (1) / busy (0) |
| tgt_vcc_en | output | 1 | Target supply enable |
| tgt_rst | output | 1 | Target reset level |
| tgt_clk_en | output | 1 | Target oscillator enable |
| tgt_psen | output | 1 | Target PSEN level |
| tgt_ale_prog | output | 1 | ALE level / active-low program strobe |
| tgt_ea | output | 1 | EA logic level |
| tgt_vpp_en | output | 1 | Request for the 12 V programming voltage on EA |
| tgt_mode | output | 4 | Mode lines {P2.6, P2.7, P3.6, P3.7} |
| tgt_addr | output | ADDR_W | Byte address (port 1 low, P2.0–P2.5 high) |
| tgt_dout | output | DATA_W | Write data for the data port |
| tgt_doe | output | 1 | Drive enable for the data port |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished (held until next start) |
| err | output | 1 | Session ended in failure |
| err_timeout | output | 1 | Failure cause: 1 timeout, 0 mismatch |
| err_addr | output | ADDR_W | Address of the failing byte |

## Verification
A byte offered on the stream is taken on the first rising edge at which `s_ready` is high. Its strobe follows 2×SETUP_CYC cycles later. The write event is accepted by the target model when the strobe returns high. Read-back ends SETUP_CYC cycles after completion. Power-off edges fall one cycle apart. All stimulus changes on the falling clock edge. The target model and the monitors sample outputs only on the falling edge, half a cycle after the registers have settled. This lets settling and strobe widths be measured as whole cycle counts, and puts every flag and address check after `done` is seen high.

// File: rtl/flashprog_pkg.sv
package flashprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC,
        ST_RST,
        ST_CLK,
        ST_ARM,
        ST_FETCH,
        ST_SETUP,
        ST_VPP,
        ST_STROBE,
        ST_WAIT,
        ST_CHECK,
        ST_OFF_CLK,
        ST_OFF_RST,
        ST_OFF_VCC
    } fp_state_e;

    typedef struct packed {
        logic       vcc;
        logic       rst;
        logic       clk_en;
        logic       psen;
        logic       ale;
        logic       ea;
        logic       vpp;
        logic       doe;
        logic [3:0] mode;
    } fp_pins_t;

    // mode bit order: {P2.6, P2.7, P3.6, P3.7}
    localparam logic [3:0] MODE_OFF   = 4'b0000;
    localparam logic [3:0] MODE_IDLE  = 4'b1111;
    localparam logic [3:0] MODE_WRITE = 4'b0111;
    localparam logic [3:0] MODE_READ  = 4'b0011;

    function automatic fp_pins_t pins_for(fp_state_e st, logic poll);
        fp_pins_t p;
        p = '0;
        p.mode = MODE_OFF;
        case (st)
            ST_VCC: p.vcc = 1'b1;
            ST_RST: begin
                p.vcc = 1'b1;
                p.rst = 1'b1;
            end
            ST_CLK: begin
                p.vcc    = 1'b1;
                p.rst    = 1'b1;
                p.clk_en = 1'b1;
            end
            ST_ARM, ST_FETCH, ST_SETUP, ST_VPP, ST_STROBE, ST_WAIT, ST_CHECK: begin
                p.vcc    = 1'b1;
                p.rst    = 1'b1;
                p.clk_en = 1'b1;
                p.ea     = 1'b1;
                p.ale    = (st != ST_STROBE);
                p.vpp    = (st == ST_VPP) || (st == ST_STROBE) ||
                           (st == ST_WAIT) || (st == ST_CHECK);
                if (st == ST_ARM || st == ST_FETCH) begin
                    p.mode = MODE_IDLE;
                end else if (st == ST_CHECK || (st == ST_WAIT && poll)) begin
                    p.mode = MODE_READ;
                end else begin
                    p.mode = MODE_WRITE;
                    p.doe  = 1'b1;
                end
            end
            ST_OFF_CLK: begin
                p.vcc  = 1'b1;
                p.rst  = 1'b1;
                p.ea   = 1'b1;
                p.ale  = 1'b1;
                p.mode = MODE_IDLE;
            end
            ST_OFF_RST: p.vcc = 1'b1;
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/fp_timer.sv
module fp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/fp_judge.sv
module fp_judge #(
    parameter int DATA_W = 8
) (
    input  logic              poll_sel,
    input  logic              rdy,
    input  logic              seen_busy,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] wdata,
    output logic              write_done,
    output logic              match
);
    localparam int MSB = DATA_W - 1;

    // polling: the target returns the inverted top bit until the write ends
    assign write_done = poll_sel ? (din[MSB] == wdata[MSB]) : (seen_busy && rdy);
    assign match      = (din == wdata);
endmodule

// File: rtl/fp_pinmap.sv
module fp_pinmap
    import flashprog_pkg::*;
(
    input  fp_state_e state,
    input  logic      poll_sel,
    output fp_pins_t  pins
);
    always_comb pins = pins_for(state, poll_sel);
endmodule

// File: rtl/flashprog_seq.sv
module flashprog_seq
    import flashprog_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int DATA_W      = 8,
    parameter int MAX_BYTES   = 12288,
    parameter int PWRUP_CYC   = 2_500_000,
    parameter int SETUP_CYC   = 4,
    parameter int STROBE_CYC  = 25,
    parameter int TIMEOUT_CYC = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              poll_sel,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    input  logic [DATA_W-1:0] tgt_din,
    input  logic              tgt_rdy,
    output logic              tgt_vcc_en,
    output logic              tgt_rst,
    output logic              tgt_clk_en,
    output logic              tgt_psen,
    output logic              tgt_ale_prog,
    output logic              tgt_ea,
    output logic              tgt_vpp_en,
    output logic [3:0]        tgt_mode,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_dout,
    output logic              tgt_doe,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              err_timeout,
    output logic [ADDR_W-1:0] err_addr
);
    localparam int LONG_A  = (PWRUP_CYC > TIMEOUT_CYC) ? PWRUP_CYC : TIMEOUT_CYC;
    localparam int LONG_B  = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
    localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int TW      = $clog2(LONGEST + 1);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(MAX_BYTES - 1);

    fp_state_e         state_q, state_n;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              last_q;
    logic              seen_busy_q;
    logic              err_q, err_to_q, done_q;
    logic [ADDR_W-1:0] err_addr_q;

    logic              take, bump, fail_to, fail_mis, final_byte;
    logic              tmr_load, tmr_exp;
    logic [TW-1:0]     tmr_val;
    logic              wr_done, rb_match;
    fp_pins_t          pins;

    assign final_byte = last_q || (addr_q == LAST_ADDR);

    always_comb begin
        state_n  = state_q;
        take     = 1'b0;
        bump     = 1'b0;
        fail_to  = 1'b0;
        fail_mis = 1'b0;
        case (state_q)
            ST_IDLE:    if (start) state_n = ST_VCC;
            ST_VCC:     state_n = ST_RST;
            ST_RST:     state_n = ST_CLK;
            ST_CLK:     if (tmr_exp) state_n = ST_ARM;
            ST_ARM:     state_n = ST_FETCH;
            ST_FETCH: begin
                if (s_valid) begin
                    take    = 1'b1;
                    state_n = ST_SETUP;
                end
            end
            ST_SETUP:   if (tmr_exp) state_n = ST_VPP;
            ST_VPP:     if (tmr_exp) state_n = ST_STROBE;
            ST_STROBE:  if (tmr_exp) state_n = ST_WAIT;
            ST_WAIT: begin
                if (wr_done) begin
                    state_n = ST_CHECK;
                end else if (tmr_exp) begin
                    fail_to = 1'b1;
                    state_n = ST_OFF_CLK;
                end
            end
            ST_CHECK: begin
                if (tmr_exp) begin
                    if (!rb_match) begin
                        fail_mis = 1'b1;
                        state_n  = ST_OFF_CLK;
                    end else if (final_byte) begin
                        state_n = ST_OFF_CLK;
                    end else begin
                        bump    = 1'b1;
                        state_n = ST_FETCH;
                    end
                end
            end
            ST_OFF_CLK: state_n = ST_OFF_RST;
            ST_OFF_RST: state_n = ST_OFF_VCC;
            ST_OFF_VCC: state_n = ST_IDLE;
            default:    state_n = ST_IDLE;
        endcase
    end

    // every timed state reloads its window on entry
    assign tmr_load = (state_n != state_q);
    always_comb begin
        case (state_n)
            ST_CLK:                      tmr_val = TW'(PWRUP_CYC - 1);
            ST_SETUP, ST_VPP, ST_CHECK:  tmr_val = TW'(SETUP_CYC - 1);
            ST_STROBE:                   tmr_val = TW'(STROBE_CYC - 1);
            ST_WAIT:                     tmr_val = TW'(TIMEOUT_CYC - 1);
            default:                     tmr_val = '0;
        endcase
    end

    fp_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    fp_judge #(.DATA_W(DATA_W)) u_judge (
        .poll_sel   (poll_sel),
        .rdy        (tgt_rdy),
        .seen_busy  (seen_busy_q),
        .din        (tgt_din),
        .wdata      (data_q),
        .write_done (wr_done),
        .match      (rb_match)
    );

    fp_pinmap u_pinmap (
        .state    (state_q),
        .poll_sel (poll_sel),
        .pins     (pins)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            data_q      <= '0;
            last_q      <= 1'b0;
            seen_busy_q <= 1'b0;
            err_q       <= 1'b0;
            err_to_q    <= 1'b0;
            err_addr_q  <= '0;
            done_q      <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE && start) begin
                addr_q   <= '0;
                last_q   <= 1'b0;
                err_q    <= 1'b0;
                err_to_q <= 1'b0;
                done_q   <= 1'b0;
            end
            if (take) begin
                data_q <= s_data;
                last_q <= s_last;
            end
            if (bump) addr_q <= addr_q + 1'b1;
            if (fail_to || fail_mis) begin
                err_q      <= 1'b1;
                err_to_q   <= fail_to;
                err_addr_q <= addr_q;
            end
            if (state_q == ST_OFF_VCC) done_q <= 1'b1;
            if (state_q != ST_WAIT) seen_busy_q <= 1'b0;
            else if (!tgt_rdy)      seen_busy_q <= 1'b1;
        end
    end

    assign s_ready      = (state_q == ST_FETCH);
    assign tgt_vcc_en   = pins.vcc;
    assign tgt_rst      = pins.rst;
    assign tgt_clk_en   = pins.clk_en;
    assign tgt_psen     = pins.psen;
    assign tgt_ale_prog = pins.ale;
    assign tgt_ea       = pins.ea;
    assign tgt_vpp_en   = pins.vpp;
    assign tgt_mode     = pins.mode;
    assign tgt_doe      = pins.doe;
    assign tgt_addr     = addr_q;
    assign tgt_dout     = data_q;
    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign err          = err_q;
    assign err_timeout  = err_to_q;
    assign err_addr     = err_addr_q;
endmodule

// File: rtl/fp_seq_chk.sv
module fp_seq_chk #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              s_ready,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              tgt_vcc_en,
    input logic              tgt_rst,
    input logic              tgt_clk_en,
    input logic              tgt_psen,
    input logic              tgt_ale_prog,
    input logic              tgt_ea,
    input logic              tgt_vpp_en,
    input logic [3:0]        tgt_mode,
    input logic [ADDR_W-1:0] tgt_addr,
    input logic [DATA_W-1:0] tgt_dout
);
    // R1
    vcc_before_rst_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_rst) |-> tgt_vcc_en && $past(tgt_vcc_en));

    // R1
    rst_before_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_clk_en) |-> tgt_rst && $past(tgt_rst));

    // R2
    fetch_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> tgt_clk_en && tgt_ea && !tgt_psen && tgt_mode == 4'b1111);

    // R3
    vpp_after_setup_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tgt_vpp_en) |-> $stable(tgt_addr) && $stable(tgt_dout) &&
                              $stable(tgt_mode) && tgt_mode == 4'b0111);

    // R4
    strobe_under_vpp_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_ea && !tgt_ale_prog) |-> tgt_vpp_en);

    // R11
    clk_off_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_rst) |-> !tgt_clk_en && !tgt_ea);

    // R11
    vcc_off_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(tgt_vcc_en) |-> !tgt_rst && !tgt_ea && !tgt_clk_en && !tgt_vpp_en);

    // R9
    err_no_vpp_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !tgt_vpp_en);

    // R12
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));
endmodule

bind flashprog_seq fp_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .s_ready      (s_ready),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .tgt_vcc_en   (tgt_vcc_en),
    .tgt_rst      (tgt_rst),
    .tgt_clk_en   (tgt_clk_en),
    .tgt_psen     (tgt_psen),
    .tgt_ale_prog (tgt_ale_prog),
    .tgt_ea       (tgt_ea),
    .tgt_vpp_en   (tgt_vpp_en),
    .tgt_mode     (tgt_mode),
    .tgt_addr     (tgt_addr),
    .tgt_dout     (tgt_dout)
);

// File: tb/tb_flashprog_seq.sv
`timescale 1ns/1ps
module tb_flashprog_seq;
    localparam int ADDR_W      = 14;
    localparam int DATA_W      = 8;
    localparam int MAX_BYTES   = 6;
    localparam int PWRUP_CYC   = 40;
    localparam int SETUP_CYC   = 2;
    localparam int STROBE_CYC  = 3;
    localparam int TIMEOUT_CYC = 100;
    localparam int BUSY_LEN    = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic              poll_sel = 1'b0;
    logic              s_valid = 1'b0;
    logic [DATA_W-1:0] s_data = '0;
    logic              s_last = 1'b0;
    logic              s_ready;
    logic [DATA_W-1:0] tgt_din = '0;
    logic              tgt_rdy = 1'b1;
    logic              tgt_vcc_en, tgt_rst, tgt_clk_en, tgt_psen;
    logic              tgt_ale_prog, tgt_ea, tgt_vpp_en, tgt_doe;
    logic [3:0]        tgt_mode;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_dout;
    logic              busy, done, err, err_timeout;
    logic [ADDR_W-1:0] err_addr;

    always #2 clk = ~clk;

    flashprog_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_BYTES(MAX_BYTES),
        .PWRUP_CYC(PWRUP_CYC), .SETUP_CYC(SETUP_CYC),
        .STROBE_CYC(STROBE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .poll_sel(poll_sel),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .tgt_din(tgt_din), .tgt_rdy(tgt_rdy),
        .tgt_vcc_en(tgt_vcc_en), .tgt_rst(tgt_rst), .tgt_clk_en(tgt_clk_en),
        .tgt_psen(tgt_psen), .tgt_ale_prog(tgt_ale_prog), .tgt_ea(tgt_ea),
        .tgt_vpp_en(tgt_vpp_en), .tgt_mode(tgt_mode), .tgt_addr(tgt_addr),
        .tgt_dout(tgt_dout), .tgt_doe(tgt_doe),
        .busy(busy), .done(done), .err(err), .err_timeout(err_timeout),
        .err_addr(err_addr)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // scoreboard of accepted bytes: {addr, data}
    logic [ADDR_W+DATA_W-1:0] exp_q[$];

    // fault injection controls, written only by the stimulus process
    int corrupt_addr = -1;
    int stuck_addr   = -1;

    // target model and pin monitors, all on the falling edge
    logic [7:0] mem [0:63];
    int  busy_cnt = 0, low_len = 0, n_writes = 0, poll_reads = 0;
    int  busy_addr = -1;
    bit  wbit7 = 1'b0;
    bit  p_ale = 1'b0, p_vcc = 1'b0, p_rst = 1'b0, p_clk = 1'b0, p_ea = 1'b0, p_vpp = 1'b0;
    int  t_vcc = 0, t_rst = 0, t_clk = 0, t_clkoff = 0;

    always @(negedge clk) begin
        if (!tgt_vcc_en) busy_cnt = 0;
        if (tgt_ea && !tgt_ale_prog) low_len++;
        if (!p_ale && tgt_ale_prog && tgt_ea && low_len > 0) begin
            // R4: strobe width, one pulse per accepted byte
            chk(low_len == STROBE_CYC, "R4 strobe width", low_len, STROBE_CYC);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 strobe without byte", int'({tgt_addr, tgt_dout}), 0);
            end else begin
                logic [ADDR_W+DATA_W-1:0] item;
                item = exp_q.pop_front();
                // R8: address sequence and data
                chk(item == {tgt_addr, tgt_dout}, "R8 write addr/data",
                    int'({tgt_addr, tgt_dout}), int'(item));
            end
            mem[tgt_addr[5:0]] = tgt_dout ^ ((int'(tgt_addr) == corrupt_addr) ? 8'h01 : 8'h00);
            wbit7     = tgt_dout[7];
            busy_addr = int'(tgt_addr);
            busy_cnt  = BUSY_LEN;
            n_writes++;
            low_len = 0;
        end else if (busy_cnt > 0 && busy_addr != stuck_addr) begin
            busy_cnt--;
        end
        if (busy_cnt > 0 && tgt_mode == 4'b0011) poll_reads++;
        tgt_rdy = (busy_cnt == 0);
        if (tgt_mode == 4'b0011)
            tgt_din = (busy_cnt > 0) ? {~wbit7, 7'h2A} : mem[tgt_addr[5:0]];
        else
            tgt_din = 8'h00;

        if (tgt_vcc_en && !p_vcc) t_vcc = cyc;
        if (tgt_rst && !p_rst) begin
            t_rst = cyc;
            chk(t_rst == t_vcc + 1, "R1 reset after supply", t_rst - t_vcc, 1);
        end
        if (tgt_clk_en && !p_clk) begin
            t_clk = cyc;
            chk(t_clk == t_rst + 1, "R1 clock after reset", t_clk - t_rst, 1);
        end
        if (tgt_ea && !p_ea) begin
            chk(cyc - t_clk >= PWRUP_CYC, "R2 settle time", cyc - t_clk, PWRUP_CYC);
            chk(!tgt_psen && tgt_ale_prog && tgt_mode == 4'b1111, "R2 armed pins",
                int'({tgt_psen, tgt_ale_prog, tgt_mode}), int'({1'b0, 1'b1, 4'b1111}));
        end
        if (tgt_vpp_en && !p_vpp)
            chk(tgt_mode == 4'b0111 && tgt_doe, "R3 write mode at vpp",
                int'({tgt_doe, tgt_mode}), int'({1'b1, 4'b0111}));
        if (!tgt_clk_en && p_clk) t_clkoff = cyc;
        if (!tgt_rst && p_rst)
            chk(cyc == t_clkoff + 1 && !tgt_ea, "R11 reset off after clock",
                cyc - t_clkoff, 1);
        if (!tgt_vcc_en && p_vcc)
            chk(cyc == t_clkoff + 2, "R11 supply off last", cyc - t_clkoff, 2);

        p_ale = tgt_ale_prog; p_vcc = tgt_vcc_en; p_rst = tgt_rst;
        p_clk = tgt_clk_en;   p_ea  = tgt_ea;     p_vpp = tgt_vpp_en;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog expired", cyc, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // driver: offers one byte, pushes the expected write once it is taken
    task automatic send(input logic [7:0] d, input bit lst, inout int acc);
        s_valid = 1'b1;
        s_data  = d;
        s_last  = lst;
        forever begin
            if (s_ready) begin
                exp_q.push_back({ADDR_W'(acc), d});
                acc++;
                @(negedge clk);
                break;
            end
            if (done) break;
            @(negedge clk);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic session(input bit poll, input int nbytes, input bit use_last,
                           input int corrupt, input int stuck, input int exp_acc,
                           input bit exp_err, input bit exp_to, input int exp_eaddr,
                           input string tag);
        int acc = 0;
        int w0;
        int p0;
        w0 = n_writes;
        p0 = poll_reads;
        corrupt_addr = corrupt;
        stuck_addr   = stuck;
        poll_sel     = poll;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int i = 0; i < nbytes; i++)
            send(8'(8'h3C + 37 * i + nbytes), use_last && (i == nbytes - 1), acc);
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(acc == exp_acc, {tag, " R8 bytes taken"}, acc, exp_acc);
        chk(n_writes - w0 == exp_acc, {tag, " R4 strobes"}, n_writes - w0, exp_acc);
        chk(exp_q.size() == 0, {tag, " R8 scoreboard drained"}, exp_q.size(), 0);
        chk(err == exp_err, {tag, " R7 err flag"}, int'(err), int'(exp_err));
        if (exp_err) begin
            chk(err_timeout == exp_to, {tag, " R9/R10 cause"}, int'(err_timeout), int'(exp_to));
            chk(int'(err_addr) == exp_eaddr, {tag, " R9/R10 err_addr"}, int'(err_addr), exp_eaddr);
        end
        if (poll)
            chk(poll_reads > p0, {tag, " R6 polled with read code"}, poll_reads - p0, 1);
        chk({tgt_vcc_en, tgt_rst, tgt_clk_en, tgt_ea, tgt_vpp_en, tgt_ale_prog} == 6'b0 && !busy,
            {tag, " R11 all off after done"},
            int'({tgt_vcc_en, tgt_rst, tgt_clk_en, tgt_ea, tgt_vpp_en, tgt_ale_prog}), 0);
        while (exp_q.size() > 0) void'(exp_q.pop_front());
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12
        chk({tgt_vcc_en, tgt_rst, tgt_clk_en, tgt_psen, tgt_ale_prog, tgt_ea, tgt_vpp_en,
             tgt_doe, tgt_mode} == 12'b0, "R12 target pins after reset",
            int'({tgt_vcc_en, tgt_rst, tgt_clk_en, tgt_psen, tgt_ale_prog, tgt_ea,
                  tgt_vpp_en, tgt_doe, tgt_mode}), 0);
        chk({s_ready, busy, done, err} == 4'b0, "R12 status after reset",
            int'({s_ready, busy, done, err}), 0);

        // R5: ready/busy completion, four bytes ending on last
        session(1'b0, 4, 1'b1, -1, -1, 4, 1'b0, 1'b0, 0, "rdy");
        // R6: data polling completion
        session(1'b1, 3, 1'b1, -1, -1, 3, 1'b0, 1'b0, 0, "poll");
        // R8: no last flag, stops at MAX_BYTES
        session(1'b0, 8, 1'b0, -1, -1, MAX_BYTES, 1'b0, 1'b0, 0, "cap");
        // R10: read-back mismatch at address 2
        session(1'b1, 5, 1'b1, 2, -1, 3, 1'b1, 1'b0, 2, "mismatch");
        // R9: target never leaves busy at address 1
        session(1'b0, 4, 1'b1, -1, 1, 2, 1'b1, 1'b1, 1, "timeout");
        // R5 again: clean session after a failure clears the error
        session(1'b0, 2, 1'b1, -1, -1, 2, 1'b0, 1'b0, 0, "recover");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule